// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 1K x 8 serial memory that sits on a two-wire bus as a slave. It oversamples the bus clock and data lines with a fast system clock and recognises start and stop conditions. It receives and transmits bytes, acknowledges, and reads the acknowledge of the master. The memory array and its write timing live in a separate controller. The engine reaches that controller through a plain port: an address, a one-cycle write strobe with data, a read-data input that follows the address combinationally, and a busy input.

A transfer opens with a control byte. That byte holds a fixed type code, one select bit that must match a pin, the two high address bits, and the direction bit. In a write, a low-address byte follows, then any number of data bytes. Each data byte is presented on the write port and advances the shared 10-bit address counter. A read streams bytes from that same counter for as long as the master acknowledges. A random read is therefore a write that carries only an address, then a new start with a read control byte.

Top module: `twi_mem_engine`

## Requirements
- R1: After reset, and after every stop condition, the engine does not pull SDA low (sda_oe_o = 0).
- R2: The control byte is received MSB first as 1,0,1,0, select, A9, A8, R/W (1 = read). It is acknowledged only if the first four bits match 1010 and the select bit equals sel_i. Otherwise no acknowledge is given and the rest of the transfer is ignored until the next start: no bit is driven and no write strobe occurs.
- R3: An SDA fall while SCL is high is a start. An SDA rise while SCL is high is a stop, and a stop mid-byte returns the engine to standby without changing the address counter.
- R4: SDA is sampled on SCL rising edges. The engine changes its SDA drive only while SCL is low, and it acknowledges by holding SDA low through the ninth clock.
- R5: In a write, the second byte provides address bits 7..0, and A9..A8 come from the control byte. Each following data byte is acknowledged and appears on the write port as one mem_we_o pulse at the current counter value, and the counter then increments by one.
- R6: A write transfer that ends after the address byte loads the counter and produces no write strobe.
- R7: A read sends the byte at the counter MSB first, the first bit appearing after the control byte's acknowledge clock. The counter increments after each byte sent, wraps from 1023 to 0, and a read control byte does not alter it.
- R8: A master acknowledge after a read byte makes the engine send the next byte. A missing acknowledge makes the engine release SDA and drive nothing more until a start.
- R9: While busy_i is 1, a matching control byte is not acknowledged.
- R10: A start in the middle of any byte abandons it and begins control-byte reception at once. A partial data byte is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sel_i | input | 1 | Device select pin; tie low when unused |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Memory controller is in its write cycle |
| mem_addr_o | output | 10 | Address counter, used for reads and writes |
| mem_we_o | output | 1 | One-cycle write strobe per received data byte |
| mem_wdata_o | output | 8 | Write data, valid with mem_we_o |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, combinational |

## Verification
The bench plays a bus master against a memory model and issues single-byte and multi-byte writes, random reads through an address-only write, current-address reads, and a sequential read across address 1023. Control bytes with the wrong select bit, the wrong type code and the busy input raised must all go unacknowledged and cause no write strobe, which separates correct decoding from blanket acceptance. A stop inside an address byte and a repeated start inside a data byte show whether aborted bytes leave the counter and the memory untouched. Clocking a further byte after a master no-acknowledge shows whether the engine truly lets go of the line.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
    localparam int MEM_AW = 10;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } st_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_p,
    output logic stop_p
);
    localparam int LAST = STAGES;

    typedef struct packed {
        logic [LAST:0] scl;
        logic [LAST:0] sda;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.scl = {r_q.scl[LAST-1:0], scl_i};
        r_d.sda = {r_q.sda[LAST-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    // index LAST-1 is the synchronized sample, LAST the one before it
    assign scl_s    = r_q.scl[LAST-1];
    assign sda_s    = r_q.sda[LAST-1];
    assign scl_rise = !r_q.scl[LAST] &&  r_q.scl[LAST-1];
    assign scl_fall =  r_q.scl[LAST] && !r_q.scl[LAST-1];
    assign start_p  =  r_q.scl[LAST] &&  r_q.scl[LAST-1] &&  r_q.sda[LAST] && !r_q.sda[LAST-1];
    assign stop_p   =  r_q.scl[LAST] &&  r_q.scl[LAST-1] && !r_q.sda[LAST] &&  r_q.sda[LAST-1];

    // R3: a line event is never both start and stop, and never on an SCL edge
    a_r3_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || stop_p) |-> !(start_p && stop_p) && !scl_rise && !scl_fall);
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q, addr_d;

    always_comb begin
        addr_d = addr_q;
        if (ld)       addr_d = ld_val;
        else if (inc) addr_d = addr_q + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R7: the counter wraps from the top location to zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && addr_q == {AW{1'b1}}) |=> addr_q == '0);
endmodule

// File: rtl/twi_mem_engine.sv
module twi_mem_engine
    import twi_mem_pkg::*;
#(
    parameter int AW        = MEM_AW,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          sel_i,
    output logic          sda_oe_o,
    input  logic          busy_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i
);
    localparam int HI_W = AW - BYTE_W;

    typedef struct packed {
        st_e             st;
        logic [3:0]      bitcnt;
        logic [7:0]      sh;
        logic [HI_W-1:0] hi;
        logic            oe;
        logic            mack;
        logic            rw;
    } eng_t;

    eng_t r_q, r_d;

    logic scl_s, scl_rise, scl_fall, sda_s, start_p, stop_p;
    logic we_c, ld_c, inc_c;
    logic [AW-1:0] ld_val_c;

    twi_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    twi_addr_ctr #(.AW(AW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_c),
        .ld_val (ld_val_c),
        .inc    (inc_c),
        .addr   (mem_addr_o)
    );

    always_comb begin
        r_d      = r_q;
        we_c     = 1'b0;
        ld_c     = 1'b0;
        inc_c    = 1'b0;
        ld_val_c = {r_q.hi, r_q.sh};
        if (start_p) begin
            r_d.st     = ST_DEV;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
        end else if (stop_p) begin
            r_d.st     = ST_IDLE;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
        end else begin
            case (r_q.st)
                ST_DEV, ST_ADDR, ST_WDAT: begin
                    if (scl_rise) begin
                        r_d.sh     = {r_q.sh[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        if (r_q.st == ST_DEV) begin
                            if (r_q.sh[7:4] == DEV_CODE && r_q.sh[3] == sel_i && !busy_i) begin
                                r_d.oe = 1'b1;
                                r_d.rw = r_q.sh[0];
                                r_d.hi = r_q.sh[HI_W:1];
                                r_d.st = ST_DEV_ACK;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_ADDR) begin
                            ld_c   = 1'b1;
                            r_d.oe = 1'b1;
                            r_d.st = ST_ADDR_ACK;
                        end else begin
                            we_c   = 1'b1;
                            inc_c  = 1'b1;
                            r_d.oe = 1'b1;
                            r_d.st = ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (r_q.rw) begin
                            r_d.sh = mem_rdata_i;
                            r_d.oe = ~mem_rdata_i[7];
                            r_d.st = ST_RDAT;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (r_q.bitcnt == 4'd8) begin
                            r_d.bitcnt = '0;
                            r_d.oe     = 1'b0;
                            inc_c      = 1'b1;
                            r_d.st     = ST_RACK;
                        end else begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                            r_d.oe = ~r_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.sh = mem_rdata_i;
                            r_d.oe = ~mem_rdata_i[7];
                            r_d.st = ST_RDAT;
                        end else begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o    = r_q.oe;
    assign mem_we_o    = we_c;
    assign mem_wdata_o = r_q.sh;

    // R1: standby never drives the line
    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sda_oe_o);
    // R4: the drive changes only while the synchronized clock is low
    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
    // R5: a write strobe is followed by a counter advance of one
    a_r5_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> mem_addr_o == $past(mem_addr_o) + AW'(1));
    // R9: a control byte closing while busy is not acknowledged
    a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEV && scl_fall && busy_i && !start_p && !stop_p) |=> !sda_oe_o);
endmodule

// File: tb/tb_twi_mem_engine.sv
module tb_twi_mem_engine;
    localparam int AW = 10;
    localparam int Q  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b1, busy = 1'b0;
    logic          sda_oe;
    logic [AW-1:0] maddr;
    logic          mwe;
    logic [7:0]    mwd;
    logic [7:0]    mrd;
    logic [7:0]    mem   [0:(1<<AW)-1];
    logic [7:0]    model [0:(1<<AW)-1];
    logic          sda_bus;

    assign sda_bus = sda_m & ~sda_oe;
    assign mrd     = mem[maddr];
    always @(posedge clk) if (mwe) mem[maddr] <= mwd;

    twi_mem_engine dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sel_i(sel),
        .sda_oe_o(sda_oe), .busy_i(busy), .mem_addr_o(maddr), .mem_we_o(mwe),
        .mem_wdata_o(mwd), .mem_rdata_i(mrd)
    );

    int total = 0, bad = 0;
    int wexp_a[$], wexp_d[$];
    int rexp[$], robs[$];
    string rtag[$];

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // write-port monitor
    always @(negedge clk) begin
        if (rst_n && mwe) begin
            if (wexp_a.size() == 0) begin
                total++; bad++;
                $display("FAIL R6/R2 unexpected write: got=%0h:%0h expected=none", maddr, mwd);
            end else begin
                chk("R5 write address", int'(maddr), wexp_a.pop_front());
                chk("R5 write data", int'(mwd), wexp_d.pop_front());
            end
        end
    end

    // read-byte monitor
    initial forever begin
        @(negedge clk);
        while (robs.size() > 0 && rexp.size() > 0)
            chk(rtag.pop_front(), robs.pop_front(), rexp.pop_front());
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog: got=hung expected=done");
        finish_run();
    end

    task automatic tq(); repeat (Q) @(posedge clk); #1; endtask
    task automatic m_start(); sda_m = 1; tq(); scl_m = 1; tq(); sda_m = 0; tq(); scl_m = 0; tq(); endtask
    task automatic m_stop(); sda_m = 0; tq(); scl_m = 1; tq(); sda_m = 1; tq(); endtask
    task automatic wbit(input logic b); sda_m = b; tq(); scl_m = 1; tq(); tq(); scl_m = 0; tq(); endtask
    task automatic rbit(output logic b);
        sda_m = 1; tq(); scl_m = 1; tq(); b = sda_bus; tq(); scl_m = 0; tq();
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(ack);
    endtask
    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(mack ? 1'b0 : 1'b1);
    endtask
    function automatic logic [7:0] ctl(input logic s, input logic [1:0] hi, input logic rw);
        return {4'b1010, s, hi, rw};
    endfunction
    task automatic exp_rd(string tag, int a);
        rexp.push_back(int'(model[a])); rtag.push_back(tag);
    endtask
    task automatic get_rd(input logic mack);
        logic [7:0] v;
        recv_byte(v, mack);
        robs.push_back(int'(v));
    endtask
    task automatic exp_wr(int a, int d);
        wexp_a.push_back(a); wexp_d.push_back(d); model[a] = d[7:0];
    endtask
    task automatic set_addr(int a, string tag);
        logic ack;
        m_start();
        send_byte(ctl(1'b1, a[9:8], 1'b0), ack); chk({tag, " control ack"}, ack, 0);
        send_byte(a[7:0], ack);                  chk({tag, " address ack"}, ack, 0);
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        for (int i = 0; i < (1 << AW); i++) begin
            mem[i] = 8'(i * 7 + 3); model[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        tq();
        chk("R1 reset leaves SDA released", sda_oe, 0);

        // byte write at 0x2F5 (A9..A8 = 10)
        set_addr(12'h2F5, "R2/R4");
        exp_wr(12'h2F5, 8'hA5);
        send_byte(8'hA5, ack); chk("R5 data byte ack", ack, 0);
        m_stop();
        chk("R1 stop leaves SDA released", sda_oe, 0);

        // random read via address-only write, sequential second byte
        set_addr(12'h2F5, "R6");
        m_start();
        send_byte(ctl(1'b1, 2'b10, 1'b1), ack); chk("R2 read control ack", ack, 0);
        exp_rd("R6 random read first byte", 12'h2F5); get_rd(1'b1);
        exp_rd("R8 next byte after ack", 12'h2F6);    get_rd(1'b0);
        m_stop();

        // current-address read; high bits in a read control byte are not used
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack); chk("R7 current read ack", ack, 0);
        exp_rd("R7 current address read", 12'h2F7); get_rd(1'b0);
        m_stop();

        // wrap 1023 -> 0
        set_addr(12'h3FF, "R7 wrap");
        m_start();
        send_byte(ctl(1'b1, 2'b11, 1'b1), ack);
        exp_rd("R7 byte at 1023", 12'h3FF); get_rd(1'b1);
        exp_rd("R7 wrapped to 0", 0);       get_rd(1'b0);
        m_stop();

        // page write of three bytes, then read back
        set_addr(12'h010, "R5 page");
        exp_wr(12'h010, 8'h11); send_byte(8'h11, ack);
        exp_wr(12'h011, 8'h22); send_byte(8'h22, ack);
        exp_wr(12'h012, 8'h33); send_byte(8'h33, ack); chk("R5 last page byte ack", ack, 0);
        m_stop();
        set_addr(12'h010, "R5 readback");
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack);
        exp_rd("R5 readback 0", 12'h010); get_rd(1'b1);
        exp_rd("R5 readback 1", 12'h011); get_rd(1'b1);
        exp_rd("R5 readback 2", 12'h012); get_rd(1'b0);
        m_stop();

        // select mismatch: no ack, rest ignored
        m_start();
        send_byte(ctl(1'b0, 2'b00, 1'b0), ack); chk("R2 select mismatch no ack", ack, 1);
        send_byte(8'h40, ack); chk("R2 ignored address byte", ack, 1);
        send_byte(8'h5A, ack); chk("R2 ignored data byte", ack, 1);
        m_stop();
        // wrong type code
        m_start();
        send_byte(8'b1011_1000, ack); chk("R2 wrong type code no ack", ack, 1);
        m_stop();
        // select pin low
        sel = 1'b0;
        m_start();
        send_byte(ctl(1'b0, 2'b00, 1'b1), ack); chk("R2 select pin low ack", ack, 0);
        exp_rd("R2 read with select low", 12'h013); get_rd(1'b0);
        m_stop();
        sel = 1'b1;

        // busy controller
        busy = 1'b1;
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b0), ack); chk("R9 busy no ack", ack, 1);
        send_byte(8'h70, ack);
        send_byte(8'h99, ack); chk("R9 data ignored while busy", ack, 1);
        m_stop();
        busy = 1'b0;
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack); chk("R9 ack once idle", ack, 0);
        exp_rd("R9 counter unchanged by busy transfer", 12'h014); get_rd(1'b0);
        m_stop();

        // repeated start inside a data byte
        set_addr(12'h050, "R10");
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack); chk("R10 restart control ack", ack, 0);
        exp_rd("R10 read after repeated start", 12'h050); get_rd(1'b0);
        m_stop();

        // release after master no-ack
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack);
        exp_rd("R8 read before no-ack", 12'h051); get_rd(1'b0);
        recv_byte(v, 1'b0);
        chk("R8 line released after no-ack", v, 8'hFF);
        m_stop();

        // stop in the middle of the address byte
        m_start();
        send_byte(ctl(1'b1, 2'b11, 1'b0), ack);
        wbit(1'b0); wbit(1'b0);
        m_stop();
        chk("R3 stop mid-byte releases", sda_oe, 0);
        m_start();
        send_byte(ctl(1'b1, 2'b00, 1'b1), ack); chk("R3 start after stop ack", ack, 0);
        exp_rd("R3 counter kept after aborted byte", 12'h052); get_rd(1'b0);
        m_stop();

        repeat (20) @(posedge clk);
        chk("R7 all read bytes observed", robs.size() + rexp.size(), 0);
        chk("R5 all expected writes seen", wexp_a.size(), 0);
        finish_run();
    end
endmodule